// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between the CPU bus and an on-chip flash array. While rewrite mode is switched on, it watches write and read cycles to the flash address space. Write cycles carry command bytes, and the block collects the addresses, data words and confirmations that multi-cycle commands need. It then hands program, erase and lock-bit operations to an abstract flash back end over a one-cycle request and a done pulse. It holds a status register and one lock bit per block. Read cycles return array data, the status register or a block's lock state, depending on the current read mode.

The sequencer is a single state machine with eight states. From `S_IDLE`, a write of 41 goes to `S_PG_DATA`, 20 goes to `S_CONF_BERASE`, A7 goes to `S_CONF_EALL` and 77 goes to `S_CONF_LOCK`. FF, 70, 50 and 71 only change the read mode or the status register, and the machine stays in `S_IDLE`.

In `S_PG_DATA`, the 128th word in sequence goes to `S_ISSUE` if the page's block is unlocked and to `S_IDLE` if it is locked. A word out of sequence goes to `S_IDLE` with a sequence error. `S_CONF_BERASE` and `S_CONF_LOCK` go to `S_ISSUE` on a D0 confirmation. `S_CONF_EALL` goes to `S_SCAN` on a D0 confirmation. Any other byte in these three states goes to `S_IDLE` with a sequence error, and a block erase aimed at a locked block also goes back to `S_IDLE`.

`S_SCAN` walks the blocks in ascending order. It goes to `S_ISSUE` for each unlocked block and returns to `S_IDLE` after the last block. `S_ISSUE` always goes to `S_WAIT`. On a done pulse, `S_WAIT` goes back to `S_SCAN` while an erase-all still has blocks left, and to `S_IDLE` otherwise.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rewrite_en` is 0, write cycles change nothing, no request is issued, and reads return `arr_rdata`.
- R2: Only `bus_wdata[7:0]` of a command write is decoded. The upper byte of a command write is ignored.
- R3: After reset and after a write of FF, reads return `arr_rdata`. After a write of 70, reads at any address return the status register in bits 7:0 and zero above. The status bits are: bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 sequence error, and all other bits 0.
- R4: A write of 50 clears status bits 5, 4 and 3.
- R5: A write of 41, followed by 128 word writes to page base + 0, 2, …, FE (the page base has address bits 7:0 at zero), drives `pbuf_we` with `pbuf_idx` = 0..127 and the written data. After the last word, exactly one request is issued with `be_op` = 1 (program) and `be_addr` = page base.
- R6: A page word at any address other than the expected one sets status bit 3, issues no request, and returns reads to array mode.
- R7: A write of 20, followed by D0 at an address in block b, issues one request with `be_op` = 2 (erase) and `be_addr` = the highest even address of block b. The block index is `bus_addr[15:12]`.
- R8: Any confirmation byte other than D0 after 20, A7 or 77 sets status bit 3, issues no request, and returns reads to array mode.
- R9: A write of 77, followed by D0 at block b, issues a request with `be_op` = 3. When done arrives, block b is locked. After a write of 71, a read at a block's address returns bit 6 = 0 if the block is locked, 1 if it is unlocked, and all other bits 0.
- R10: A block erase or page program aimed at a locked block issues no request. It sets status bit 5 (erase) or bit 4 (program), and reads then return status.
- R11: A write of A7, followed by D0, issues one erase request per unlocked block, in ascending block order, and skips every locked block.
- R12: Status bit 7 reads 0 from the cycle after the confirming write until done. Writes other than 70 are ignored while busy. After an operation, reads return status.
- R13: `be_req` is high for exactly one cycle per operation, and the next request comes only after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rewrite_en | input | 1 | Rewrite mode enable; commands accepted only when 1 |
| bus_wr | input | 1 | Write cycle strobe |
| bus_rd | input | 1 | Read cycle strobe |
| bus_addr | input | ADDR_W | Byte address of the cycle |
| bus_wdata | input | DATA_W | Write data |
| arr_rdata | input | DATA_W | Array data for the current address |
| bus_rdata | output | DATA_W | Read data (array, status or lock state) |
| pbuf_we | output | 1 | Page buffer word write strobe |
| pbuf_idx | output | PG_LOG2-1 | Word index within the page |
| pbuf_data | output | DATA_W | Page buffer word |
| be_req | output | 1 | One-cycle operation request to the back end |
| be_op | output | 2 | Operation: 1 program, 2 erase, 3 lock |
| be_addr | output | ADDR_W | Page base or block address of the operation |
| be_done | input | 1 | Back end completion pulse |

## Verification
Read data is combinational from the current read mode. A read one negative edge after a command write therefore already shows the new mode, and the bench's read task samples 1 ns after driving the address.

`be_req` rises in the cycle after the rising edge that takes the confirming write or the last page word. For an erase-all, each later request comes two cycles after the previous done pulse, plus one cycle for every locked block skipped. `pbuf_we` is valid in the same cycle as its page write.

A monitor samples `be_req` and the page strobe 5 ns after each falling edge. At that point it pops the expected operation or word that the driver queued beforehand, so a missing, extra or reordered request is caught at the cycle it appears.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PG_DATA,
        S_CONF_BERASE,
        S_CONF_EALL,
        S_CONF_LOCK,
        S_SCAN,
        S_ISSUE,
        S_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_LOCK
    } rd_mode_t;

    localparam logic [1:0] OP_PROG  = 2'd1;
    localparam logic [1:0] OP_ERASE = 2'd2;
    localparam logic [1:0] OP_LOCK  = 2'd3;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_PAGE_PROG = 8'h41;
    localparam logic [7:0] CMD_BLK_ERASE = 8'h20;
    localparam logic [7:0] CMD_ERASE_ALL = 8'hA7;
    localparam logic [7:0] CMD_LOCK_PROG = 8'h77;
    localparam logic [7:0] CMD_RD_LOCK   = 8'h71;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

endpackage

// File: rtl/fcs_lock_bits.sv
module fcs_lock_bits #(
    parameter int IDX_W   = 4,
    localparam int NUM_BLK = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic [IDX_W-1:0]   qa_idx,
    input  logic [IDX_W-1:0]   qb_idx,
    output logic               qa_locked,
    output logic               qb_locked,
    output logic [NUM_BLK-1:0] locked_vec
);

    logic [NUM_BLK-1:0] lock_q;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[g] <= 1'b0;
            end else if (set_en && (set_idx == IDX_W'(g))) begin
                lock_q[g] <= 1'b1;
            end
        end
    end

    assign qa_locked  = lock_q[qa_idx];
    assign qb_locked  = lock_q[qb_idx];
    assign locked_vec = lock_q;

    // R9: a lock, once set, stays set
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lock_q) & ~lock_q) == '0));

    // R9: a lock bit changes only through the set strobe
    a_r9_lock_only_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en |=> $stable(lock_q));

endmodule

// File: rtl/fcs_status.sv
module fcs_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_seq,
    input  logic       set_prog,
    input  logic       set_erase,
    input  logic       ready,
    output logic [7:0] sr
);

    logic erase_err_q, prog_err_q, seq_err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
            seq_err_q   <= 1'b0;
        end else if (clr) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
            seq_err_q   <= 1'b0;
        end else begin
            erase_err_q <= erase_err_q | set_erase;
            prog_err_q  <= prog_err_q  | set_prog;
            seq_err_q   <= seq_err_q   | set_seq;
        end
    end

    assign sr = {ready, 1'b0, erase_err_q, prog_err_q, seq_err_q, 3'b000};

    // R4: a clear empties all three error bits
    a_r4_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sr[5:3] == 3'b000));

    // R8: a sequence error request is visible on the next cycle
    a_r8_seq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_seq && !clr) |=> sr[3]);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int BLK_LOG2 = 12,
    parameter int PG_LOG2  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rewrite_en,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   arr_rdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                pbuf_we,
    output logic [PG_LOG2-2:0]  pbuf_idx,
    output logic [DATA_W-1:0]   pbuf_data,
    output logic                be_req,
    output logic [1:0]          be_op,
    output logic [ADDR_W-1:0]   be_addr,
    input  logic                be_done
);

    localparam int BLK_IDX_W = ADDR_W - BLK_LOG2;
    localparam int NUM_BLK   = 1 << BLK_IDX_W;
    localparam int PG_IDX_W  = PG_LOG2 - 1;
    localparam int PG_BASE_W = ADDR_W - PG_LOG2;
    localparam logic [BLK_IDX_W-1:0] LAST_BLK = BLK_IDX_W'(NUM_BLK - 1);

    function automatic logic [ADDR_W-1:0] blk_addr(input logic [BLK_IDX_W-1:0] i);
        return {i, {(BLK_LOG2-1){1'b1}}, 1'b0};
    endfunction

    seq_state_t                state_q, state_d;
    rd_mode_t                  rd_q, rd_d;
    logic [PG_BASE_W-1:0]      pg_base_q, pg_base_d;
    logic [PG_IDX_W-1:0]       pg_idx_q, pg_idx_d;
    logic [1:0]                op_q, op_d;
    logic [ADDR_W-1:0]         addr_q, addr_d;
    logic                      eall_q, eall_d;
    logic [BLK_IDX_W-1:0]      scan_q, scan_d;

    logic                      wr_cmd;
    logic [7:0]                cbyte;
    logic [BLK_IDX_W-1:0]      bus_blk, pg_blk, qb_idx;
    logic                      qa_locked, qb_locked;
    logic [NUM_BLK-1:0]        locked_vec;
    logic                      lock_set;
    logic                      clr_sr, set_seq, set_prog, set_erase;
    logic                      ready;
    logic [7:0]                sr;
    logic                      pg_ok;

    assign wr_cmd  = bus_wr && rewrite_en;
    assign cbyte   = bus_wdata[7:0];
    assign bus_blk = bus_addr[ADDR_W-1 -: BLK_IDX_W];
    assign pg_blk  = pg_base_q[PG_BASE_W-1 -: BLK_IDX_W];
    assign ready   = !(state_q inside {S_SCAN, S_ISSUE, S_WAIT});
    assign pg_ok   = (bus_addr[PG_LOG2-1:0] == {pg_idx_q, 1'b0}) &&
                     ((pg_idx_q == '0) || (bus_addr[ADDR_W-1:PG_LOG2] == pg_base_q));

    fcs_lock_bits #(.IDX_W(BLK_IDX_W)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (lock_set),
        .set_idx    (addr_q[ADDR_W-1 -: BLK_IDX_W]),
        .qa_idx     (bus_blk),
        .qb_idx     (qb_idx),
        .qa_locked  (qa_locked),
        .qb_locked  (qb_locked),
        .locked_vec (locked_vec)
    );

    fcs_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_sr),
        .set_seq   (set_seq),
        .set_prog  (set_prog),
        .set_erase (set_erase),
        .ready     (ready),
        .sr        (sr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            rd_q      <= RD_ARRAY;
            pg_base_q <= '0;
            pg_idx_q  <= '0;
            op_q      <= OP_PROG;
            addr_q    <= '0;
            eall_q    <= 1'b0;
            scan_q    <= '0;
        end else begin
            state_q   <= state_d;
            rd_q      <= rd_d;
            pg_base_q <= pg_base_d;
            pg_idx_q  <= pg_idx_d;
            op_q      <= op_d;
            addr_q    <= addr_d;
            eall_q    <= eall_d;
            scan_q    <= scan_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        rd_d      = rd_q;
        pg_base_d = pg_base_q;
        pg_idx_d  = pg_idx_q;
        op_d      = op_q;
        addr_d    = addr_q;
        eall_d    = eall_q;
        scan_d    = scan_q;
        qb_idx    = bus_blk;
        lock_set  = 1'b0;
        clr_sr    = 1'b0;
        set_seq   = 1'b0;
        set_prog  = 1'b0;
        set_erase = 1'b0;
        pbuf_we   = 1'b0;
        be_req    = 1'b0;

        unique case (state_q)
            S_IDLE: begin
                if (wr_cmd) begin
                    unique case (cbyte)
                        CMD_RD_ARRAY:  rd_d = RD_ARRAY;
                        CMD_RD_STATUS: rd_d = RD_STATUS;
                        CMD_CLR_STAT:  clr_sr = 1'b1;
                        CMD_RD_LOCK:   rd_d = RD_LOCK;
                        CMD_PAGE_PROG: begin
                            state_d  = S_PG_DATA;
                            pg_idx_d = '0;
                        end
                        CMD_BLK_ERASE: state_d = S_CONF_BERASE;
                        CMD_ERASE_ALL: state_d = S_CONF_EALL;
                        CMD_LOCK_PROG: state_d = S_CONF_LOCK;
                        default: ;
                    endcase
                end
            end
            S_PG_DATA: begin
                qb_idx = pg_blk;
                if (wr_cmd) begin
                    if (!pg_ok) begin
                        set_seq = 1'b1;
                        rd_d    = RD_ARRAY;
                        state_d = S_IDLE;
                    end else begin
                        pbuf_we = 1'b1;
                        if (pg_idx_q == '0) begin
                            pg_base_d = bus_addr[ADDR_W-1:PG_LOG2];
                        end
                        pg_idx_d = pg_idx_q + 1'b1;
                        if (pg_idx_q == '1) begin
                            if (qb_locked) begin
                                set_prog = 1'b1;
                                rd_d     = RD_STATUS;
                                state_d  = S_IDLE;
                            end else begin
                                op_d    = OP_PROG;
                                addr_d  = {pg_base_q, {PG_LOG2{1'b0}}};
                                rd_d    = RD_STATUS;
                                state_d = S_ISSUE;
                            end
                        end
                    end
                end
            end
            S_CONF_BERASE: begin
                if (wr_cmd) begin
                    if (cbyte != CMD_CONFIRM) begin
                        set_seq = 1'b1;
                        rd_d    = RD_ARRAY;
                        state_d = S_IDLE;
                    end else if (qb_locked) begin
                        set_erase = 1'b1;
                        rd_d      = RD_STATUS;
                        state_d   = S_IDLE;
                    end else begin
                        op_d    = OP_ERASE;
                        addr_d  = blk_addr(bus_blk);
                        eall_d  = 1'b0;
                        rd_d    = RD_STATUS;
                        state_d = S_ISSUE;
                    end
                end
            end
            S_CONF_LOCK: begin
                if (wr_cmd) begin
                    if (cbyte != CMD_CONFIRM) begin
                        set_seq = 1'b1;
                        rd_d    = RD_ARRAY;
                        state_d = S_IDLE;
                    end else begin
                        op_d    = OP_LOCK;
                        addr_d  = blk_addr(bus_blk);
                        eall_d  = 1'b0;
                        rd_d    = RD_STATUS;
                        state_d = S_ISSUE;
                    end
                end
            end
            S_CONF_EALL: begin
                if (wr_cmd) begin
                    if (cbyte != CMD_CONFIRM) begin
                        set_seq = 1'b1;
                        rd_d    = RD_ARRAY;
                        state_d = S_IDLE;
                    end else begin
                        eall_d  = 1'b1;
                        scan_d  = '0;
                        rd_d    = RD_STATUS;
                        state_d = S_SCAN;
                    end
                end
            end
            S_SCAN: begin
                qb_idx = scan_q;
                if (!qb_locked) begin
                    op_d    = OP_ERASE;
                    addr_d  = blk_addr(scan_q);
                    state_d = S_ISSUE;
                end else if (scan_q == LAST_BLK) begin
                    eall_d  = 1'b0;
                    state_d = S_IDLE;
                end else begin
                    scan_d = scan_q + 1'b1;
                end
            end
            S_ISSUE: begin
                be_req  = 1'b1;
                state_d = S_WAIT;
            end
            S_WAIT: begin
                if (be_done) begin
                    lock_set = (op_q == OP_LOCK);
                    if (eall_q && (scan_q != LAST_BLK)) begin
                        scan_d  = scan_q + 1'b1;
                        state_d = S_SCAN;
                    end else begin
                        eall_d  = 1'b0;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase

        // the only write accepted while busy selects the status read mode
        if (!ready && wr_cmd && (cbyte == CMD_RD_STATUS)) begin
            rd_d = RD_STATUS;
        end
    end

    assign pbuf_idx  = pg_idx_q;
    assign pbuf_data = bus_wdata;
    assign be_op     = op_q;
    assign be_addr   = addr_q;

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (!rewrite_en) begin
                bus_rdata = arr_rdata;
            end else begin
                unique case (rd_q)
                    RD_STATUS: bus_rdata[7:0] = sr;
                    RD_LOCK:   bus_rdata[6]   = !qa_locked;
                    default:   bus_rdata      = arr_rdata;
                endcase
            end
        end
    end

    // R1: no command leaves the idle state while rewrite mode is off
    a_r1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !rewrite_en) |=> (state_q == S_IDLE));

    // R10: no erase or program request targets a locked block
    a_r10_no_locked_req: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && (be_op != OP_LOCK)) |-> !locked_vec[be_addr[ADDR_W-1 -: BLK_IDX_W]]);

    // R13: request is a single-cycle pulse
    a_r13_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |=> !be_req);

    // R12: status reports busy until done arrives
    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req || (state_q == S_WAIT && !be_done)) |=> !sr[7]);

    // R5: program requests carry a page-aligned address
    a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_op == OP_PROG) |-> (be_addr[PG_LOG2-1:0] == '0));

    // R8: a bad confirmation returns to idle with the sequence error set
    a_r8_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {S_CONF_BERASE, S_CONF_EALL, S_CONF_LOCK}) && wr_cmd &&
         (cbyte != CMD_CONFIRM)) |=> (state_q == S_IDLE && sr[3]));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rewrite_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] arr_rdata;
    logic [15:0] bus_rdata;
    logic        pbuf_we;
    logic [6:0]  pbuf_idx;
    logic [15:0] pbuf_data;
    logic        be_req;
    logic [1:0]  be_op;
    logic [15:0] be_addr;
    logic        be_done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic [17:0] exp_q[$];
    logic [22:0] pbuf_q[$];

    always #10 clk = ~clk;

    assign arr_rdata = bus_addr ^ 16'h5A5A;

    flash_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .rewrite_en(rewrite_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .arr_rdata(arr_rdata), .bus_rdata(bus_rdata),
        .pbuf_we(pbuf_we), .pbuf_idx(pbuf_idx), .pbuf_data(pbuf_data),
        .be_req(be_req), .be_op(be_op), .be_addr(be_addr), .be_done(be_done)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [15:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        logic [15:0] d = '0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            bread(16'h0000, d);
            if (d[7]) break;
        end
        chk(tag, 16'(d[7]), 16'h0001);
    endtask

    // Back end model: done pulse eight cycles after each request
    initial begin
        forever begin
            @(negedge clk);
            if (be_req) begin
                repeat (8) @(negedge clk);
                be_done = 1'b1;
                @(negedge clk);
                be_done = 1'b0;
            end
        end
    end

    // Monitor: compares requests and page words against the queues
    initial begin
        logic prev_req = 1'b0;
        logic [17:0] e;
        logic [22:0] p;
        forever begin
            @(negedge clk);
            #5;
            if (be_req) begin
                if (prev_req) begin
                    n_chk++; n_err++;
                    $display("FAIL R13: got request high two cycles expected one");
                end
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R10: got request %h/%h expected none", be_op, be_addr);
                end else begin
                    e = exp_q.pop_front();
                    if ({be_op, be_addr} !== e) begin
                        n_err++;
                        $display("FAIL R11: got %h expected %h", {be_op, be_addr}, e);
                    end
                end
            end
            prev_req = be_req;
            if (pbuf_we) begin
                n_chk++;
                if (pbuf_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R6: got page word %h expected none", pbuf_idx);
                end else begin
                    p = pbuf_q.pop_front();
                    if ({pbuf_idx, pbuf_data} !== p) begin
                        n_err++;
                        $display("FAIL R5: got %h expected %h", {pbuf_idx, pbuf_data}, p);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state: array mode
        @(negedge clk);
        bread(16'h0100, d); chk("R3 reset array", d, 16'h0100 ^ 16'h5A5A);

        // R1 rewrite mode off: writes ignored
        bwrite(16'h0000, 16'h0070);
        bread(16'h0100, d); chk("R1 status ignored", d, 16'h0100 ^ 16'h5A5A);
        bwrite(16'h3FFE, 16'h0020);
        bwrite(16'h3FFE, 16'h00D0);
        repeat (4) @(negedge clk);
        rewrite_en = 1'b1;
        bread(16'h0200, d); chk("R1 still array", d, 16'h0200 ^ 16'h5A5A);

        // R2 upper byte ignored
        bwrite(16'h0000, 16'hAB70);
        bread(16'h0456, d); chk("R2 status mode", d, 16'h0080);
        bwrite(16'h0000, 16'h12FF);
        bread(16'h0456, d); chk("R3 back to array", d, 16'h0456 ^ 16'h5A5A);

        // R7 block erase with R12 busy behaviour
        exp_q.push_back({2'd2, 16'h3FFE});
        bwrite(16'h3000, 16'h0020);
        bwrite(16'h3123, 16'h00D0);
        bread(16'h0000, d); chk("R12 busy at issue", d, 16'h0000);
        bwrite(16'h0000, 16'h00FF);
        bread(16'h0000, d); chk("R12 FF ignored while busy", d, 16'h0000);
        wait_ready("R7 erase completes");
        bread(16'h0000, d); chk("R12 status after op", d, 16'h0080);

        // R8 bad confirmation, R4 clear
        bwrite(16'h0000, 16'h0020);
        bwrite(16'h3FFE, 16'h0055);
        bread(16'h0300, d); chk("R8 array after bad confirm", d, 16'h0300 ^ 16'h5A5A);
        bwrite(16'h0000, 16'h0070);
        bread(16'h0000, d); chk("R8 sequence bit", d, 16'h0088);
        bwrite(16'h0000, 16'h0050);
        bread(16'h0000, d); chk("R4 cleared", d, 16'h0080);

        // R9 lock block 5 and read lock state
        exp_q.push_back({2'd3, 16'h5FFE});
        bwrite(16'h0000, 16'h0077);
        bwrite(16'h5FFE, 16'h00D0);
        wait_ready("R9 lock completes");
        bwrite(16'h0000, 16'h0071);
        bread(16'h5FFE, d); chk("R9 block 5 locked", d, 16'h0000);
        bread(16'h4FFE, d); chk("R9 block 4 unlocked", d, 16'h0040);

        // R10 erase of locked block refused
        bwrite(16'h0000, 16'h0020);
        bwrite(16'h5FFE, 16'h00D0);
        repeat (12) @(negedge clk);
        bread(16'h0000, d); chk("R10 erase refused", d, 16'h00A0);
        bwrite(16'h0000, 16'h0050);

        // R5 page program at 0x1200
        exp_q.push_back({2'd1, 16'h1200});
        bwrite(16'h0000, 16'h0041);
        for (int i = 0; i < 128; i++) begin
            pbuf_q.push_back({7'(i), 16'(16'hC000 + 3 * i)});
            bwrite(16'h1200 + 16'(2 * i), 16'(16'hC000 + 3 * i));
        end
        wait_ready("R5 program completes");
        chk("R5 words consumed", 16'(pbuf_q.size()), 16'h0000);

        // R10 program into locked block refused
        bwrite(16'h0000, 16'h0041);
        for (int i = 0; i < 128; i++) begin
            pbuf_q.push_back({7'(i), 16'(i)});
            bwrite(16'h5300 + 16'(2 * i), 16'(i));
        end
        repeat (12) @(negedge clk);
        bread(16'h0000, d); chk("R10 program refused", d, 16'h0090);
        bwrite(16'h0000, 16'h0050);

        // R6 out-of-sequence page word
        bwrite(16'h0000, 16'h0041);
        pbuf_q.push_back({7'd0, 16'h1111});
        bwrite(16'h2000, 16'h1111);
        bwrite(16'h2004, 16'h2222);
        bread(16'h0500, d); chk("R6 array after abort", d, 16'h0500 ^ 16'h5A5A);
        bwrite(16'h0000, 16'h0070);
        bread(16'h0000, d); chk("R6 sequence bit", d, 16'h0088);
        bwrite(16'h0000, 16'h0050);

        // R11 erase all unlocked, blocks 5 and 9 locked
        exp_q.push_back({2'd3, 16'h9FFE});
        bwrite(16'h0000, 16'h0077);
        bwrite(16'h9000, 16'h00D0);
        wait_ready("R9 second lock");
        for (int b = 0; b < 16; b++) begin
            if (b != 5 && b != 9) exp_q.push_back({2'd2, 4'(b), 12'hFFE});
        end
        bwrite(16'h0000, 16'h00A7);
        bwrite(16'h0000, 16'h00D0);
        wait_ready("R11 erase all completes");
        repeat (4) @(negedge clk);
        chk("R11 all requests seen", 16'(exp_q.size()), 16'h0000);
        bread(16'h0000, d); chk("R11 no errors", d, 16'h0080);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule